// File: doc/BRIEF.md
# Eight-Channel Match Timer Bank

This block holds eight match channels, numbered 4 to 11, that sit next to a separate set of four basic channels on one register bus. Each channel has its own counter, a match value and a control word. A channel compares either against its own counter or against a counter owned by another channel, following a fixed sharing map. A match can clear the counter it was compared against, can re-arm the channel for periodic operation, and can raise a pending flag. The pending flags of all eight channels drive one combined interrupt line.

Each counter advances on a tick chosen from eight tick-enable inputs. The rates of those inputs are produced elsewhere. A tick input that stays low stops the counter, and a stopped counter never produces a match. Software reads the counters, match values, controls, status, enables and a snapshot register through a simple register port. Read data arrives one cycle after the read strobe. Reading the counter of channel 9 or 11 can capture the counter of the channel just below it into the snapshot register.

Top module: `mtb_bank`

## Requirements
- R1: After a synchronous reset, every counter, match value, control word, pending bit, enable bit and the snapshot read as zero, and `irq` is low.
- R2: Channel index i (channel 4+i) with control bit 7 set compares against counter i. With bit 7 clear it compares against counter S(i), where S = {0,0,0,0,4,4,6,6} for i = 0..7.
- R3: Control bits 2:0 pick the tick input `tick_src[sel]`. Each cycle in which that input is high, counter i increases by one. When the input is low the counter holds and nothing can match against it. A register write to the counter takes priority over a tick.
- R4: A match happens when a tick moves the compared counter onto the channel's match value. If control bit 3 is set, that counter becomes 0 instead of taking the match value.
- R5: With control bit 6 set, a channel stays armed after a match and matches again every time the condition recurs. With bit 6 clear, it is disarmed after one match until its match or counter register is written.
- R6: For channels 8 to 11 (i = 4..7), control bit 8 forces the tick selection to input 0, whatever bits 2:0 hold.
- R7: Reading the counter of channel 9 or 11 (i = 5 or 7) while its control bit 9 is set copies counter i-1 into the snapshot register. The snapshot holds its value until the next capture. No other read captures.
- R8: Control words of channels 4 to 7 keep bits 7:0 and read higher bits as zero. Those of channels 8 to 11 keep bits 9:0.
- R9: `irq` is a register that is high in the cycle after any status bit 4..11 is set. A write to status clears the bits where the write data has a one. `irq` falls only once no bit 4..11 remains set.
- R10: A match on channel 4+i sets status bit 4+i only if bit 4+i of the 12-bit enable register is set. The enable register reads back all 12 bits.
- R11: Byte addresses on the word-aligned bus: counter i at 0x40+4i, match i at 0x80+4i, control i at 0xC0+4i, status at 0x14 (bits 3:0 read zero), enable at 0x1C, snapshot at 0x20. Any other address reads zero and ignores writes. `rdata` is valid the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| tick_src | input | 8 | Tick-enable inputs, one per source selection |
| irq | output | 1 | Combined interrupt for channels 4 to 11 |

## Verification
The assertions check, on every cycle, the rules that hold per channel:
- a counter whose tick is low and that is not written stays unchanged;
- a one-shot channel is disarmed after it matches;
- reset-on-match leaves its own counter at zero;
- a disabled channel never gains a pending bit;
- the interrupt follows the pending bits.

Only the bench scenarios can show the other behaviours:
- the sharing map;
- forcing the tick to input 0;
- the pairing of reads with snapshot captures;
- the control width masks;
- the partial status clear that keeps `irq` high;
- the refire of a periodic channel.

Each of these needs a sequence of register accesses with expected values.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
  localparam int NCH    = 8;
  localparam int CH_W   = $clog2(NCH);
  localparam int SEL_W  = 3;
  localparam int NSRC   = 1 << SEL_W;
  localparam int BASE   = 4;              // status bit of the first channel
  localparam int CTL_W  = 10;

  // control bit positions
  localparam int B_RSTM  = 3;
  localparam int B_PRD   = 6;
  localparam int B_OWN   = 7;
  localparam int B_FRC0  = 8;
  localparam int B_SNAP  = 9;

  // byte addresses
  localparam logic [7:0] A_STAT = 8'h14;
  localparam logic [7:0] A_IEN  = 8'h1C;
  localparam logic [7:0] A_SNAP = 8'h20;
  localparam logic [1:0] RG_CNT = 2'b01;
  localparam logic [1:0] RG_MAT = 2'b10;
  localparam logic [1:0] RG_CTL = 2'b11;

  // fixed sharing map: which counter a channel uses when not on its own
  function automatic int share_src(input int idx);
    if (idx < 4)      return 0;
    else if (idx < 6) return 4;
    else              return 6;
  endfunction
endpackage

// File: rtl/mtb_chan.sv
module mtb_chan
  import mtb_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   tick_src,
  input  logic              ctl_we,
  input  logic              mat_we,
  input  logic              cnt_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  ref_cnt,
  input  logic              ref_tick,
  input  logic              cnt_zero,
  input  logic              ien,
  input  logic              clr,
  output logic [CTL_W-1:0]  ctl,
  output logic [CNT_W-1:0]  mat,
  output logic [CNT_W-1:0]  cnt,
  output logic              tick,
  output logic              hit,
  output logic              hit_rst,
  output logic              pend,
  output logic              armed
);
  localparam bit            WIDE  = (IDX >= 4);
  localparam logic [CTL_W-1:0] CMASK = WIDE ? 10'h3FF : 10'h0FF;

  logic [SEL_W-1:0] sel;

  always_comb begin
    if (WIDE && ctl[B_FRC0]) sel = '0;
    else                     sel = ctl[SEL_W-1:0];
  end

  assign tick    = tick_src[sel];
  assign hit     = ref_tick && armed && ((ref_cnt + CNT_W'(1)) == mat);
  assign hit_rst = hit && ctl[B_RSTM];

  always_ff @(posedge clk) begin
    if (rst)         ctl <= '0;
    else if (ctl_we) ctl <= wdata[CTL_W-1:0] & CMASK;
  end

  always_ff @(posedge clk) begin
    if (rst)         mat <= '0;
    else if (mat_we) mat <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (cnt_we)   cnt <= wdata[CNT_W-1:0];
    else if (tick)     cnt <= cnt_zero ? '0 : cnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                     armed <= 1'b1;
    else if (mat_we || cnt_we)   armed <= 1'b1;
    else if (hit && !ctl[B_PRD]) armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)             pend <= 1'b0;
    else if (hit && ien) pend <= 1'b1;
    else if (clr)        pend <= 1'b0;
  end
endmodule

// File: rtl/mtb_rdmux.sv
module mtb_rdmux
  import mtb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic [7:0]                       addr,
  input  logic [NCH-1:0][CNT_W-1:0]        cnt_v,
  input  logic [NCH-1:0][CNT_W-1:0]        mat_v,
  input  logic [NCH-1:0][CTL_W-1:0]        ctl_v,
  input  logic [NCH-1:0]                   pend_v,
  input  logic [BASE+NCH-1:0]              ien_q,
  input  logic [CNT_W-1:0]                 snap_q,
  output logic [DATA_W-1:0]                data
);
  logic [CH_W-1:0] idx;
  assign idx = addr[CH_W+1:2];

  always_comb begin
    data = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr[7:6] == 2'b00) begin
        if (addr == A_STAT)      data = DATA_W'({pend_v, {BASE{1'b0}}});
        else if (addr == A_IEN)  data = DATA_W'(ien_q);
        else if (addr == A_SNAP) data = DATA_W'(snap_q);
      end else if (!addr[5]) begin
        case (addr[7:6])
          RG_CNT:  data = DATA_W'(cnt_v[idx]);
          RG_MAT:  data = DATA_W'(mat_v[idx]);
          default: data = DATA_W'(ctl_v[idx]);
        endcase
      end
    end
  end
endmodule

// File: rtl/mtb_bank.sv
module mtb_bank
  import mtb_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSRC-1:0]   tick_src,
  output logic              irq
);
  localparam int EN_W = BASE + NCH;

  logic [NCH-1:0][CNT_W-1:0] cnt_v, mat_v, ref_cnt_v;
  logic [NCH-1:0][CTL_W-1:0] ctl_v;
  logic [NCH-1:0][CH_W-1:0]  ref_idx;
  logic [NCH-1:0] tick_v, ref_tick_v, hit_v, hit_rst_v, pend_v, armed_v;
  logic [NCH-1:0] cnt_we_v, mat_we_v, ctl_we_v, zero_req;
  logic [EN_W-1:0]  ien_q;
  logic [CNT_W-1:0] snap_q;
  logic [DATA_W-1:0] rd_next;
  logic [CH_W-1:0]  a_idx;
  logic             a_ok, in_bank;

  assign a_idx   = addr[CH_W+1:2];
  assign a_ok    = (addr[1:0] == 2'b00);
  assign in_bank = a_ok && (addr[7:6] != 2'b00) && !addr[5];

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      localparam int SH = share_src(c);

      assign cnt_we_v[c] = wr_en && in_bank && addr[7:6] == RG_CNT && a_idx == CH_W'(c);
      assign mat_we_v[c] = wr_en && in_bank && addr[7:6] == RG_MAT && a_idx == CH_W'(c);
      assign ctl_we_v[c] = wr_en && in_bank && addr[7:6] == RG_CTL && a_idx == CH_W'(c);

      assign ref_idx[c]    = ctl_v[c][B_OWN] ? CH_W'(c) : CH_W'(SH);
      assign ref_cnt_v[c]  = cnt_v[ref_idx[c]];
      assign ref_tick_v[c] = tick_v[ref_idx[c]];

      mtb_chan #(.IDX(c), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
        .clk      (clk),
        .rst      (rst),
        .tick_src (tick_src),
        .ctl_we   (ctl_we_v[c]),
        .mat_we   (mat_we_v[c]),
        .cnt_we   (cnt_we_v[c]),
        .wdata    (wdata),
        .ref_cnt  (ref_cnt_v[c]),
        .ref_tick (ref_tick_v[c]),
        .cnt_zero (zero_req[c]),
        .ien      (ien_q[BASE+c]),
        .clr      (wr_en && a_ok && addr == A_STAT && wdata[BASE+c]),
        .ctl      (ctl_v[c]),
        .mat      (mat_v[c]),
        .cnt      (cnt_v[c]),
        .tick     (tick_v[c]),
        .hit      (hit_v[c]),
        .hit_rst  (hit_rst_v[c]),
        .pend     (pend_v[c]),
        .armed    (armed_v[c])
      );
    end
  endgenerate

  // a counter is cleared when any channel comparing against it resets on match
  always_comb begin
    zero_req = '0;
    for (int k = 0; k < NCH; k++)
      if (hit_rst_v[k]) zero_req[ref_idx[k]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)                                ien_q <= '0;
    else if (wr_en && a_ok && addr == A_IEN) ien_q <= wdata[EN_W-1:0];
  end

  // snapshot: odd channel of an upper pair, counter read, capture enabled
  always_ff @(posedge clk) begin
    if (rst) snap_q <= '0;
    else if (rd_en && in_bank && addr[7:6] == RG_CNT && a_idx[0] &&
             a_idx >= CH_W'(4) && ctl_v[a_idx][B_SNAP])
      snap_q <= cnt_v[a_idx - CH_W'(1)];
  end

  mtb_rdmux #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_rd (
    .addr   (addr),
    .cnt_v  (cnt_v),
    .mat_v  (mat_v),
    .ctl_v  (ctl_v),
    .pend_v (pend_v),
    .ien_q  (ien_q),
    .snap_q (snap_q),
    .data   (rd_next)
  );

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_next;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |pend_v;
  end
endmodule

// File: rtl/mtb_bank_chk.sv
module mtb_bank_chk #(
  parameter int CNT_W = 32,
  parameter int NCH   = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      irq,
  input logic [NCH-1:0]            pend_v,
  input logic [NCH-1:0]            ien_v,
  input logic [NCH-1:0]            hit_v,
  input logic [NCH-1:0]            armed_v,
  input logic [NCH-1:0]            tick_v,
  input logic [NCH-1:0]            cnt_we_v,
  input logic [NCH-1:0]            mat_we_v,
  input logic [NCH-1:0]            prd_v,
  input logic [NCH-1:0]            rstm_v,
  input logic [NCH-1:0]            own_v,
  input logic [NCH-1:0][CNT_W-1:0] cnt_v
);
  // R9: pending work raises the line on the next cycle
  a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
    (pend_v != '0) |=> irq);
  // R9: the line is only high when something was pending
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(pend_v != '0));

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_p
      // R10: a disabled channel cannot become pending
      a_r10_gate: assert property (@(posedge clk) disable iff (rst)
        (!pend_v[c] && !ien_v[c]) |=> !pend_v[c]);
      // R5: one-shot channel is disarmed after its match
      a_r5_oneshot: assert property (@(posedge clk) disable iff (rst)
        (hit_v[c] && !prd_v[c] && !cnt_we_v[c] && !mat_we_v[c]) |=> !armed_v[c]);
      // R5: periodic channel keeps its arming across a match
      a_r5_periodic: assert property (@(posedge clk) disable iff (rst)
        (hit_v[c] && prd_v[c]) |=> armed_v[c]);
      // R3: no tick and no write means the counter holds
      a_r3_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick_v[c] && !cnt_we_v[c]) |=> $stable(cnt_v[c]));
      // R4: own-counter reset on match leaves zero
      a_r4_zero: assert property (@(posedge clk) disable iff (rst)
        (hit_v[c] && rstm_v[c] && own_v[c] && !cnt_we_v[c]) |=> (cnt_v[c] == '0));
    end
  endgenerate
endmodule

bind mtb_bank mtb_bank_chk #(.CNT_W(CNT_W), .NCH(8)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .irq      (irq),
  .pend_v   (pend_v),
  .ien_v    (ien_q[11:4]),
  .hit_v    (hit_v),
  .armed_v  (armed_v),
  .tick_v   (tick_v),
  .cnt_we_v (cnt_we_v),
  .mat_we_v (mat_we_v),
  .prd_v    ({ctl_v[7][6], ctl_v[6][6], ctl_v[5][6], ctl_v[4][6],
                ctl_v[3][6], ctl_v[2][6], ctl_v[1][6], ctl_v[0][6]}),
  .rstm_v   ({ctl_v[7][3], ctl_v[6][3], ctl_v[5][3], ctl_v[4][3],
                ctl_v[3][3], ctl_v[2][3], ctl_v[1][3], ctl_v[0][3]}),
  .own_v    ({ctl_v[7][7], ctl_v[6][7], ctl_v[5][7], ctl_v[4][7],
                ctl_v[3][7], ctl_v[2][7], ctl_v[1][7], ctl_v[0][7]}),
  .cnt_v    (cnt_v)
);

// File: tb/mtb_bank_tb.sv
`timescale 1ns/1ps
module mtb_bank_tb;
  localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_N = 2'd2, OP_I = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 78;
  localparam vec_t VEC [NV] = '{
    '{OP_R, 8'hC0, 32'h0,     32'h0,     8'd1},   // R1 control reset value
    '{OP_I, 8'h00, 32'h0,     32'h0,     8'd1},   // R1 irq low
    '{OP_W, 8'hC0, 32'h3FF,   32'h0,     8'd8},
    '{OP_R, 8'hC0, 32'h0,     32'hFF,    8'd8},   // R8 narrow control
    '{OP_W, 8'hD0, 32'h3FF,   32'h0,     8'd8},
    '{OP_R, 8'hD0, 32'h0,     32'h3FF,   8'd8},   // R8 wide control
    '{OP_W, 8'hC0, 32'h081,   32'h0,     8'd3},
    '{OP_W, 8'hC0, 32'h080,   32'h0,     8'd3},
    '{OP_R, 8'h40, 32'h0,     32'h2,     8'd3},   // R3 two ticks counted
    '{OP_N, 8'h00, 32'd5,     32'h0,     8'd3},
    '{OP_R, 8'h40, 32'h0,     32'h2,     8'd3},   // R3 dead source holds
    '{OP_W, 8'h40, 32'h0,     32'h0,     8'd3},
    '{OP_W, 8'hD0, 32'h181,   32'h0,     8'd6},
    '{OP_W, 8'h1C, 32'h100,   32'h0,     8'd6},
    '{OP_W, 8'h90, 32'h1,     32'h0,     8'd6},
    '{OP_N, 8'h00, 32'd5,     32'h0,     8'd6},
    '{OP_R, 8'h50, 32'h0,     32'h0,     8'd6},   // R6 forced to source 0
    '{OP_R, 8'h14, 32'h0,     32'h0,     8'd3},   // R3 stopped never matches
    '{OP_W, 8'h1C, 32'h000,   32'h0,     8'd6},
    '{OP_W, 8'hD0, 32'h081,   32'h0,     8'd6},
    '{OP_W, 8'hD0, 32'h080,   32'h0,     8'd6},
    '{OP_R, 8'h50, 32'h0,     32'h2,     8'd6},   // R6 without force it counts
    '{OP_W, 8'h1C, 32'h030,   32'h0,     8'd2},
    '{OP_W, 8'h80, 32'h3,     32'h0,     8'd2},
    '{OP_W, 8'h84, 32'h2,     32'h0,     8'd2},
    '{OP_W, 8'hC4, 32'h002,   32'h0,     8'd2},
    '{OP_W, 8'h40, 32'h0,     32'h0,     8'd2},
    '{OP_W, 8'hC0, 32'h089,   32'h0,     8'd2},
    '{OP_N, 8'h00, 32'd8,     32'h0,     8'd2},
    '{OP_R, 8'h14, 32'h0,     32'h030,   8'd2},   // R2 shared counter fires ch5
    '{OP_I, 8'h00, 32'h1,     32'h0,     8'd9},   // R9
    '{OP_W, 8'h14, 32'h010,   32'h0,     8'd9},
    '{OP_R, 8'h14, 32'h0,     32'h020,   8'd9},   // R9 partial clear
    '{OP_I, 8'h00, 32'h1,     32'h0,     8'd9},   // R9 still high
    '{OP_W, 8'h14, 32'h020,   32'h0,     8'd9},
    '{OP_R, 8'h14, 32'h0,     32'h0,     8'd9},
    '{OP_I, 8'h00, 32'h0,     32'h0,     8'd9},   // R9 low when empty
    '{OP_N, 8'h00, 32'd10,    32'h0,     8'd5},
    '{OP_R, 8'h14, 32'h0,     32'h0,     8'd5},   // R5 one-shot no refire
    '{OP_W, 8'hC0, 32'h080,   32'h0,     8'd4},
    '{OP_W, 8'h80, 32'h1,     32'h0,     8'd4},
    '{OP_W, 8'h40, 32'h0,     32'h0,     8'd4},
    '{OP_W, 8'hC0, 32'h0C9,   32'h0,     8'd4},
    '{OP_N, 8'h00, 32'd10,    32'h0,     8'd4},
    '{OP_R, 8'h40, 32'h0,     32'h0,     8'd4},   // R4 held at zero
    '{OP_R, 8'h14, 32'h0,     32'h010,   8'd5},
    '{OP_W, 8'h14, 32'h010,   32'h0,     8'd5},
    '{OP_N, 8'h00, 32'd4,     32'h0,     8'd5},
    '{OP_R, 8'h14, 32'h0,     32'h010,   8'd5},   // R5 periodic refire
    '{OP_W, 8'hC0, 32'h080,   32'h0,     8'd9},
    '{OP_W, 8'h14, 32'h030,   32'h0,     8'd9},
    '{OP_I, 8'h00, 32'h0,     32'h0,     8'd9},   // R9
    '{OP_W, 8'h1C, 32'hFFF,   32'h0,     8'd10},
    '{OP_R, 8'h1C, 32'h0,     32'hFFF,   8'd10},  // R10 enable readback
    '{OP_W, 8'h1C, 32'h000,   32'h0,     8'd10},
    '{OP_W, 8'h88, 32'h2,     32'h0,     8'd10},
    '{OP_W, 8'hC8, 32'h081,   32'h0,     8'd10},
    '{OP_N, 8'h00, 32'd6,     32'h0,     8'd10},
    '{OP_R, 8'h14, 32'h0,     32'h0,     8'd10},  // R10 disabled match
    '{OP_I, 8'h00, 32'h0,     32'h0,     8'd10},  // R10
    '{OP_W, 8'hC8, 32'h080,   32'h0,     8'd7},
    '{OP_W, 8'h50, 32'h1234,  32'h0,     8'd7},
    '{OP_W, 8'h54, 32'h55,    32'h0,     8'd7},
    '{OP_W, 8'hD4, 32'h200,   32'h0,     8'd7},
    '{OP_R, 8'h54, 32'h0,     32'h55,    8'd7},   // R7
    '{OP_R, 8'h20, 32'h0,     32'h1234,  8'd7},   // R7 capture
    '{OP_W, 8'h50, 32'h9999,  32'h0,     8'd7},
    '{OP_W, 8'hD4, 32'h000,   32'h0,     8'd7},
    '{OP_R, 8'h54, 32'h0,     32'h55,    8'd7},
    '{OP_R, 8'h20, 32'h0,     32'h1234,  8'd7},   // R7 no capture
    '{OP_W, 8'h58, 32'hABCD,  32'h0,     8'd7},
    '{OP_W, 8'hDC, 32'h200,   32'h0,     8'd7},
    '{OP_R, 8'h5C, 32'h0,     32'h0,     8'd7},
    '{OP_R, 8'h20, 32'h0,     32'hABCD,  8'd7},   // R7 second pair
    '{OP_W, 8'hD0, 32'h280,   32'h0,     8'd7},
    '{OP_R, 8'h50, 32'h0,     32'h9999,  8'd7},
    '{OP_R, 8'h20, 32'h0,     32'hABCD,  8'd7},   // R7 even channel no capture
    '{OP_R, 8'h3C, 32'h0,     32'h0,     8'd11}   // R11 unmapped reads zero
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [7:0]  tick_src = 8'b0000_0010;
  logic        irq;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  mtb_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_src(tick_src), .irq(irq)
  );

  task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_W: wr(VEC[i].addr, VEC[i].data);
        OP_R: begin rd(VEC[i].addr, got); check(int'(VEC[i].req), got, VEC[i].exp); end
        OP_N: repeat (int'(VEC[i].data)) @(negedge clk);
        default: begin @(negedge clk); check(int'(VEC[i].req), {31'b0, irq}, VEC[i].data); end
      endcase
    end

    // R1: reset in the middle of activity returns everything to zero
    wr(8'h14, 32'hFF0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    rd(8'hD0, got); check(1, got, 32'h0);
    rd(8'h20, got); check(1, got, 32'h0);
    rd(8'h50, got); check(1, got, 32'h0);
    rd(8'h1C, got); check(1, got, 32'h0);
    check(1, {31'b0, irq}, 32'h0);

    // R3: a counter write in the same cycle as a tick wins
    wr(8'hC0, 32'h081);
    wr(8'h40, 32'h100);
    wr(8'hC0, 32'h080);
    rd(8'h40, got); check(3, got, 32'h102);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule